// File: doc/BRIEF.md
# Presettable Reload Frequency Divider

This block is a small up-counter that divides its input clock by a ratio chosen at run time. It is meant for the feedback and output paths of a digital phase-locked loop. The counter climbs towards its all-ones state. On the edge after that state it reloads a preset word. With the counter enabled and the preset held steady, the all-ones state comes back once every 2^W minus preset input clocks. The single-cycle pulse that marks it is the divided clock.

The block has an active-high asynchronous clear, a count enable and a synchronous load. The load takes the preset word on any clock edge. The width W is a parameter; the default is 4. The data path has no valid/ready handshake: the preset is a static control word sampled on each edge, and the outputs are level signals with no back-pressure. All ports are therefore plain control and status pins.

Top module: `reload_divider`

## Requirements
- R1: While `clr` is high, `count` is 0 and `div_out` is 0 at once, without waiting for a clock edge.
- R2: With `clr` low, `cnt_en` = 1, `load` = 0 and `count` not all ones, each rising edge adds one to `count`.
- R3: With `clr` low, `cnt_en` = 0, `load` = 0 and `count` not all ones, `count` keeps its value across the edge, whatever `preset` holds.
- R4: With `load` = 1 and `count` not all ones, the next edge sets `count` to `preset`.
- R5: When `count` is all ones (15 for W = 4), the next edge sets `count` to `preset`, whatever `cnt_en` and `load` are.
- R6: `div_out` is 1 exactly while `count` is all ones, and 0 in every other state.
- R7: With `cnt_en` = 1, `load` = 0 and a constant preset p below all ones, `div_out` pulses high for one cycle every 2^W − p clocks. For W = 4, p = 12 gives one pulse in 4 clocks and p = 8 gives one in 8.
- R8: A preset of all ones gives divide-by-one: once `count` reaches all ones, `div_out` stays high on every cycle.
- R9: When `load` = 1 and `cnt_en` = 1 fall in the same cycle, the load wins and `count` takes `preset` rather than incrementing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| clr | input | 1 | Asynchronous clear, active high |
| cnt_en | input | 1 | Count enable |
| load | input | 1 | Synchronous load of `preset` |
| preset | input | W | Reload word; ratio is 2^W − preset |
| count | output | W | Current counter state |
| div_out | output | 1 | Divided clock, high only in the all-ones state |

## Verification
Two actions can fall in the same cycle: the terminal-count reload, and the ordinary load/increment/hold choice made from `load` and `cnt_en`. The bench provokes this by bringing the counter to 15 and then driving, on that exact cycle, enable low with load low, load high with a different preset, and enable high. In every case the next state must equal the preset: a hold, an increment to 0 or a stale preset counts as a failure. The divide ratio is judged separately: the bench measures the spacing of `div_out` pulses for every preset from 0 to 14 and checks that a preset of 15 keeps the output high.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  // Action taken by the counter register on the next clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_INC    = 2'd1,
    ACT_LOAD   = 2'd2,
    ACT_RELOAD = 2'd3
  } rdiv_act_e;

endpackage

// File: rtl/rdiv_term.sv
module rdiv_term #(
  parameter int W = 4
) (
  input  logic [W-1:0] count,
  output logic         term
);

  // Ripple AND chain across the count bits.
  logic [W:0] chain;

  assign chain[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_and
    assign chain[i+1] = chain[i] & count[i];
  end

  assign term = chain[W];

endmodule

// File: rtl/rdiv_decide.sv
module rdiv_decide
  import rdiv_pkg::*;
(
  input  logic      term,
  input  logic      load,
  input  logic      cnt_en,
  output rdiv_act_e act
);

  // Terminal reload first, then load, then increment, then hold.
  always_comb begin
    if (term)        act = ACT_RELOAD;
    else if (load)   act = ACT_LOAD;
    else if (cnt_en) act = ACT_INC;
    else             act = ACT_HOLD;
  end

endmodule

// File: rtl/rdiv_state.sv
module rdiv_state
  import rdiv_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  rdiv_act_e    act,
  input  logic [W-1:0] preset,
  input  logic         load,
  input  logic         cnt_en,
  input  logic         term,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] nxt;

  always_comb begin
    unique case (act)
      ACT_RELOAD: nxt = preset;
      ACT_LOAD:   nxt = preset;
      ACT_INC:    nxt = count + ONE;
      default:    nxt = count;
    endcase
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) count <= '0;
    else     count <= nxt;
  end

  // R2: enabled counting adds one outside the terminal state
  p_inc_step_r2: assert property (@(posedge clk) disable iff (clr)
    (cnt_en && !load && !term) |=> (count == $past(count) + ONE));

  // R3: idle inputs keep the state
  p_hold_keep_r3: assert property (@(posedge clk) disable iff (clr)
    (!cnt_en && !load && !term) |=> $stable(count));

  // R4 and R9: load takes the preset, even with enable high
  p_load_take_r4: assert property (@(posedge clk) disable iff (clr)
    (load && !term) |=> (count == $past(preset)));

  // R5: terminal state always reloads
  p_term_reload_r5: assert property (@(posedge clk) disable iff (clr)
    term |=> (count == $past(preset)));

endmodule

// File: rtl/reload_divider.sv
module reload_divider
  import rdiv_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         cnt_en,
  input  logic         load,
  input  logic [W-1:0] preset,
  output logic [W-1:0] count,
  output logic         div_out
);

  localparam logic [W-1:0] ALL_ONES = '1;

  logic      term;
  rdiv_act_e act;

  rdiv_term #(.W(W)) u_term (
    .count (count),
    .term  (term)
  );

  rdiv_decide u_decide (
    .term   (term),
    .load   (load),
    .cnt_en (cnt_en),
    .act    (act)
  );

  rdiv_state #(.W(W)) u_state (
    .clk    (clk),
    .clr    (clr),
    .act    (act),
    .preset (preset),
    .load   (load),
    .cnt_en (cnt_en),
    .term   (term),
    .count  (count)
  );

  assign div_out = term;

  // R6/R7: a pulse lasts one cycle unless the preset is all ones
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (clr)
    (div_out && preset != ALL_ONES) |=> !div_out);

  // R8: all-ones preset keeps the output high
  p_div_one_r8: assert property (@(posedge clk) disable iff (clr)
    (div_out && preset == ALL_ONES) |=> div_out);

endmodule

// File: tb/test_reload_divider.sv
module test_reload_divider;

  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int TOP = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         clr = 1'b1;
  logic         cnt_en = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic         div_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int    q_cnt[$];
  string q_tag[$];
  int    model = 0;
  bit    samp_div;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_divider #(.W(W)) i_reload_divider (
    .clk     (clk),
    .clr     (clr),
    .cnt_en  (cnt_en),
    .load    (load),
    .preset  (preset),
    .count   (count),
    .div_out (div_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: sample the output, drive one cycle, push the expected state.
  task automatic step(input bit en, input bit ld, input int pre, input string tag);
    int nxt;
    @(negedge clk);
    samp_div = div_out;
    cnt_en = en;
    load   = ld;
    preset = W'(pre);
    if (model == TOP)  nxt = pre;
    else if (ld)       nxt = pre;
    else if (en)       nxt = (model + 1) & TOP;
    else               nxt = model;
    model = nxt;
    q_cnt.push_back(nxt);
    q_tag.push_back(tag);
  endtask

  // Monitor: compare the design against the queue after each edge.
  always @(posedge clk) begin
    #1;
    if (!clr && q_cnt.size() > 0) begin
      int e;
      string t;
      e = q_cnt.pop_front();
      t = q_tag.pop_front();
      check(int'(count) == e, t, int'(count), e);
      check(div_out == (e == TOP), "R6", int'(div_out), int'(e == TOP));
    end
  end

  task automatic drain();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD * 2 + 1);
    check(count == '0, "R1", int'(count), 0);
    check(div_out == 1'b0, "R1", int'(div_out), 0);
    @(negedge clk);
    clr = 1'b0;
    model = 0;

    // R2: counting up
    for (int i = 0; i < 5; i++) step(1, 0, 9, "R2");
    // R3: hold with a changing preset
    step(0, 0, 3, "R3");
    step(0, 0, 14, "R3");
    step(0, 0, 0, "R3");
    // R4: load
    step(0, 1, 9, "R4");
    // R9: load beats increment
    step(1, 1, 3, "R9");
    step(1, 0, 3, "R2");

    // R5: reload at terminal, with enable low / load with new preset / enable high
    step(0, 1, 13, "R4");
    step(1, 0, 13, "R2");
    step(1, 0, 13, "R2");
    step(0, 0, 6, "R5");
    step(0, 1, 15, "R4");
    step(0, 1, 2, "R5");
    step(0, 1, 15, "R4");
    step(1, 0, 11, "R5");
    step(0, 1, 14, "R4");
    step(0, 0, 14, "R3");
    step(1, 0, 0, "R2");
    step(1, 1, 7, "R5");
    drain();

    // R1: asynchronous clear between edges
    step(1, 0, 7, "R2");
    drain();
    @(negedge clk);
    #1;
    clr = 1'b1;
    #1;
    check(count == '0, "R1", int'(count), 0);
    check(div_out == 1'b0, "R1", int'(div_out), 0);
    @(posedge clk);
    #1;
    check(count == '0, "R1", int'(count), 0);
    @(negedge clk);
    clr = 1'b0;
    model = 0;

    // R7: division ratio for every preset below all ones
    for (int p = 0; p < TOP; p++) begin
      int ratio;
      int k;
      int last_hi;
      int gap;
      ratio = (TOP + 1) - p;
      last_hi = -1;
      gap = -1;
      step(1, 1, p, "R4");
      k = 0;
      for (int c = 0; c < 3 * ratio + 2; c++) begin
        step(1, 0, p, "R7");
        if (samp_div) begin
          if (last_hi >= 0) gap = k - last_hi;
          last_hi = k;
        end
        k++;
      end
      check(gap == ratio, "R7", gap, ratio);
    end

    // R8: divide-by-one
    begin
      int hi;
      step(1, 1, TOP, "R4");
      step(1, 0, TOP, "R8");
      hi = 0;
      for (int c = 0; c < 10; c++) begin
        step(1, 0, TOP, "R8");
        if (samp_div) hi++;
      end
      check(hi == 10, "R8", hi, 10);
    end
    drain();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule